// File: doc/BRIEF.md
# Round-Robin Event Dispatcher for Calorimeter Tower Data

This block sits on a preprocessor card that, on each bunch crossing, receives the tower words of one detector slice. Whole events are dealt out to ten downstream processing nodes in a fixed rotation. Each node has its own output lane. The block serialises all tower words of one event onto the lane of the chosen node, one word per clock. Each node therefore takes in a complete event over several clocks and does not receive a spatial piece of every event.

A per-node enable mask takes a node out of service. Its slot in the rotation stays in place, but any event that falls in that slot is discarded and counted. The other nodes keep their usual share of events, so the system keeps its full spatial coverage at a reduced event rate. Each lane has a double buffer, so a new event can be accepted while the previous frame is still being sent. A bunch-counter-zero pulse brings the rotation back to node 0. When the parameter `NUM_COPIES` is 2, a second set of lanes carries an exact copy of the first. Cards at a region boundary use this copy to feed two destinations.

Top module: `tm_event_distributor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows every `lane_valid` bit at 0 and `drop_count` at 0. The rotation pointer is at node 0, so the first event after reset goes to node 0.
- R2: Each event (`ev_valid` high at an edge) takes the slot at the rotation pointer, after which the pointer moves to the next node, wrapping from node 9 to node 0. If the target lane is idle, the first word of its frame shows on that lane in the cycle after the capture edge.
- R3: When `bc0` is high at an edge, the pointer returns to node 0 first. An event in the same cycle goes to node 0 and the pointer moves on to node 1.
- R4: A frame is `TOWERS` consecutive valid words, sending tower 0 first (tower k sits at `ev_towers[k*9 +: 9]`). A lane word has this layout: bit 13 is the start flag, bits 12:9 are the event number, and bits 8:0 are the tower word (bit 8 is the flag bit, bits 7:0 are the energy). The start flag is set on the first word only. The event-number field is zero on every other word.
- R5: An event whose slot belongs to a node with its `node_en` bit at 0 is discarded. Nothing appears on that lane, the pointer still advances, and `drop_count` goes up by 1 in the next cycle.
- R6: An event accepted while its lane is still sending is held in the second buffer. Its frame starts in the cycle right after the last word of the current frame, with no idle cycle between.
- R7: An event whose lane already holds a frame in progress plus a full second buffer is discarded, and `drop_count` goes up by 1. This does not apply when the frame in progress is on its last word. Frames already held are sent unchanged.
- R8: With `NUM_COPIES` = 2, lane n+10 carries the same valid bit and word as lane n in every cycle.
- R9: The event number is the count of `ev_valid` cycles since reset, modulo 16. Dropped events also use up a number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bc0 | input | 1 | Bunch-counter-zero pulse; sends the rotation back to node 0 |
| ev_valid | input | 1 | An event is present on `ev_towers` this cycle |
| ev_towers | input | TOWERS*9 | Tower words of the event; tower k at bits k*9+8 down to k*9 |
| node_en | input | NUM_NODES | Per-node enable; 0 drops that node's slot |
| lane_valid | output | NUM_COPIES*NUM_NODES | Lane n carries a word this cycle |
| lane_word | output | NUM_COPIES*NUM_NODES*14 | Lane n word at bits n*14+13 down to n*14 |
| drop_count | output | CNT_W | Wrapping count of discarded events |

## Verification
The main risk is a rotation pointer that has gone wrong. It shows at once as a frame on the wrong lane, at the first word after the capture edge. A buffer index or occupancy flag that has gone wrong shows as a frame that is short or too long, a missing or doubled start flag, or a gap between back-to-back frames, all within one frame time of nine clocks. The scoreboard keeps its own model of the rotation, of each lane's occupancy and of the event numbers. It compares every lane, and the drop counter, every cycle. Any disagreement therefore shows up in the cycle in which it first becomes visible.

// File: rtl/tmd_pkg.sv
// Package: shared widths and word layout for the round-robin event dispatcher.
// Assumes a tower word of 8-bit energy plus one flag bit.
package tmd_pkg;
    localparam int TOWER_W = 9;                      // {flag, energy[7:0]}
    localparam int EVN_W   = 4;                      // event-number field
    localparam int LANE_W  = 1 + EVN_W + TOWER_W;    // {start, evnum, tower}

    // Assemble one lane word; the event number is carried on the start word only.
    function automatic logic [LANE_W-1:0] pack_word(input logic start,
                                                    input logic [EVN_W-1:0] num,
                                                    input logic [TOWER_W-1:0] tw);
        return {start, (start ? num : {EVN_W{1'b0}}), tw};
    endfunction
endpackage

// File: rtl/tmd_rotor.sv
// Module: rotation pointer and event numbering.
// Assumes bc0 takes priority over the stored pointer within the same cycle.
module tmd_rotor #(
    parameter int NUM_NODES = 10,
    localparam int PW = $clog2(NUM_NODES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bc0,
    input  logic                     ev_valid,
    output logic [PW-1:0]            sel,
    output logic [PW-1:0]            ptr_q,
    output logic [tmd_pkg::EVN_W-1:0] evnum
);
    localparam logic [PW-1:0] LAST = PW'(NUM_NODES - 1);

    logic [tmd_pkg::EVN_W-1:0] count_q;

    // Slot in effect this cycle: bc0 homes the rotation before the event is placed.
    always_comb sel = bc0 ? '0 : ptr_q;

    assign evnum = count_q;

    // Advance pointer once per event and keep the running event number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            count_q <= '0;
        end else begin
            if (ev_valid) begin
                ptr_q   <= (sel == LAST) ? '0 : sel + 1'b1;
                count_q <= count_q + 1'b1;
            end else if (bc0) begin
                ptr_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/tmd_lane.sv
// Module: one node lane, a double-buffered serialiser.
// Assumes TOWERS >= 2; the front buffer is shifting out and the back buffer is waiting.
// A load that finds both buffers busy (front not on its last word) is refused.
module tmd_lane #(
    parameter int TOWERS = 9,
    localparam int IW = $clog2(TOWERS),
    localparam int DW = TOWERS * tmd_pkg::TOWER_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [DW-1:0]             towers_i,
    input  logic [tmd_pkg::EVN_W-1:0] evnum_i,
    output logic                      valid_o,
    output logic [tmd_pkg::LANE_W-1:0] word_o,
    output logic                      overflow_o
);
    import tmd_pkg::*;

    logic [DW-1:0]    front_q, back_q;
    logic [EVN_W-1:0] front_num_q, back_num_q;
    logic             front_busy_q, back_full_q;
    logic [IW-1:0]    idx_q;
    logic             front_done;

    // Current output word, taken straight from the front buffer.
    always_comb begin
        front_done = front_busy_q && (idx_q == IW'(TOWERS - 1));
        valid_o    = front_busy_q;
        word_o     = front_busy_q
                   ? pack_word(idx_q == '0, front_num_q, front_q[idx_q*TOWER_W +: TOWER_W])
                   : '0;
        overflow_o = load && front_busy_q && !front_done && back_full_q;
    end

    // Buffer sequencing: shift, promote back to front, accept or refuse loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_busy_q <= 1'b0;
            back_full_q  <= 1'b0;
            idx_q        <= '0;
            front_q      <= '0;
            back_q       <= '0;
            front_num_q  <= '0;
            back_num_q   <= '0;
        end else if (front_done) begin
            idx_q <= '0;
            if (back_full_q) begin
                front_q     <= back_q;
                front_num_q <= back_num_q;
                back_full_q <= load;
                if (load) begin
                    back_q     <= towers_i;
                    back_num_q <= evnum_i;
                end
            end else begin
                front_busy_q <= load;
                if (load) begin
                    front_q     <= towers_i;
                    front_num_q <= evnum_i;
                end
            end
        end else if (front_busy_q) begin
            idx_q <= idx_q + 1'b1;
            if (load && !back_full_q) begin
                back_q      <= towers_i;
                back_num_q  <= evnum_i;
                back_full_q <= 1'b1;
            end
        end else if (load) begin
            front_q      <= towers_i;
            front_num_q  <= evnum_i;
            front_busy_q <= 1'b1;
            idx_q        <= '0;
        end
    end
endmodule

// File: rtl/tm_event_distributor.sv
// Module: top of the round-robin event dispatcher.
// Deals whole events to NUM_NODES lanes in rotation, counts discarded events and
// replicates the lane set NUM_COPIES times (1 or 2).
module tm_event_distributor #(
    parameter int NUM_NODES  = 10,
    parameter int TOWERS     = 9,
    parameter int NUM_COPIES = 2,
    parameter int CNT_W      = 16,
    localparam int PW = $clog2(NUM_NODES),
    localparam int DW = TOWERS * tmd_pkg::TOWER_W,
    localparam int LW = tmd_pkg::LANE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bc0,
    input  logic                               ev_valid,
    input  logic [DW-1:0]                      ev_towers,
    input  logic [NUM_NODES-1:0]               node_en,
    output logic [NUM_COPIES*NUM_NODES-1:0]    lane_valid,
    output logic [NUM_COPIES*NUM_NODES*LW-1:0] lane_word,
    output logic [CNT_W-1:0]                   drop_count
);
    logic [PW-1:0]             sel, rr_ptr;
    logic [tmd_pkg::EVN_W-1:0] evnum;
    logic [NUM_NODES-1:0]      base_valid, ovf;
    logic [NUM_NODES*LW-1:0]   base_word;
    logic                      slot_off, drop_inc;

    tmd_rotor #(.NUM_NODES(NUM_NODES)) rotor_i (
        .clk(clk), .rst_n(rst_n), .bc0(bc0), .ev_valid(ev_valid),
        .sel(sel), .ptr_q(rr_ptr), .evnum(evnum)
    );

    for (genvar n = 0; n < NUM_NODES; n++) begin : g_lane
        logic ld;
        // Load this lane when the event's slot is this node and the node is enabled.
        always_comb ld = ev_valid && (sel == PW'(n)) && node_en[n];
        tmd_lane #(.TOWERS(TOWERS)) lane_i (
            .clk(clk), .rst_n(rst_n), .load(ld), .towers_i(ev_towers),
            .evnum_i(evnum), .valid_o(base_valid[n]),
            .word_o(base_word[n*LW +: LW]), .overflow_o(ovf[n])
        );
    end

    // A discarded event is one landing on a disabled slot or a full lane.
    always_comb begin
        slot_off = ev_valid && !node_en[sel];
        drop_inc = slot_off || (|ovf);
    end

    // Running count of discarded events.
    always_ff @(posedge clk) begin
        if (!rst_n)        drop_count <= '0;
        else if (drop_inc) drop_count <= drop_count + 1'b1;
    end

    // Replicate the lane set for boundary cards.
    assign lane_valid = {NUM_COPIES{base_valid}};
    assign lane_word  = {NUM_COPIES{base_word}};
endmodule

// File: rtl/tmd_checker.sv
// Module: protocol checker for tm_event_distributor, attached by bind.
// Assumes TOWERS >= 2 so a start word is always followed by a data word.
module tmd_checker #(
    parameter int NUM_NODES = 10,
    parameter int CNT_W     = 16,
    localparam int PW = $clog2(NUM_NODES),
    localparam int LW = tmd_pkg::LANE_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bc0,
    input logic                      ev_valid,
    input logic [NUM_NODES-1:0]      node_en,
    input logic [PW-1:0]             rr_ptr,
    input logic [NUM_NODES-1:0]      lane_valid,
    input logic [NUM_NODES*LW-1:0]   lane_word,
    input logic [CNT_W-1:0]          drop_count
);
    logic [PW-1:0] exp_next;
    always_comb exp_next = (rr_ptr == PW'(NUM_NODES - 1)) ? '0 : rr_ptr + 1'b1;

    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rr_ptr < PW'(NUM_NODES));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !bc0 |=> rr_ptr == $past(exp_next));

    assert_bc0_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bc0 && !ev_valid |=> rr_ptr == '0);

    assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

    for (genvar n = 0; n < NUM_NODES; n++) begin : g_chk
        logic sof;
        assign sof = lane_word[n*LW + LW - 1];

        assert_sof_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
            sof |-> lane_valid[n]);

        assert_frame_cont_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lane_valid[n] && sof |=> lane_valid[n] && !lane_word[n*LW + LW - 1]);

        assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_valid[n] && !node_en[n] |=> !lane_valid[n]);
    end
endmodule

bind tm_event_distributor tmd_checker #(.NUM_NODES(NUM_NODES), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bc0(bc0), .ev_valid(ev_valid), .node_en(node_en),
    .rr_ptr(rr_ptr), .lane_valid(lane_valid[NUM_NODES-1:0]),
    .lane_word(lane_word[NUM_NODES*tmd_pkg::LANE_W-1:0]), .drop_count(drop_count)
);

// File: tb/tm_event_distributor_tb_top.sv
// Scoreboard bench: the driver task models rotation, occupancy and numbering and
// queues expected lane words; a negedge monitor pops and compares every cycle.
module tm_event_distributor_tb_top;
    localparam int NN = 10;
    localparam int T  = 9;
    localparam int NC = 2;
    localparam int CW = 16;
    localparam int LW = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bc0 = 1'b0;
    logic              ev_valid = 1'b0;
    logic [T*9-1:0]    ev_towers = '0;
    logic [NN-1:0]     node_en = '1;
    logic [NC*NN-1:0]  lane_valid;
    logic [NC*NN*LW-1:0] lane_word;
    logic [CW-1:0]     drop_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [LW-1:0] exp_q [NN][$];
    int            m_ptr  = 0;
    int            m_drop = 0;
    logic [3:0]    m_evn  = '0;

    always #4 clk = ~clk;   // 125 MHz

    tm_event_distributor #(.NUM_NODES(NN), .TOWERS(T), .NUM_COPIES(NC), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bc0(bc0), .ev_valid(ev_valid), .ev_towers(ev_towers),
        .node_en(node_en), .lane_valid(lane_valid), .lane_word(lane_word),
        .drop_count(drop_count)
    );

    function automatic logic [8:0] tw(input int e, input int k);
        return 9'((e * 37 + k * 11 + 5) & 32'h1FF);
    endfunction

    // Drive one cycle of stimulus and update the expected model at the capture edge.
    task automatic drive(input bit ev, input bit b0, input int eid);
        #1;
        ev_valid = ev;
        bc0      = b0;
        for (int k = 0; k < T; k++) ev_towers[k*9 +: 9] = tw(eid, k);
        @(posedge clk);
        if (b0) m_ptr = 0;
        if (ev) begin
            int tgt;
            tgt   = m_ptr;
            m_ptr = (tgt == NN - 1) ? 0 : tgt + 1;
            if (!node_en[tgt])              m_drop++;
            else if (exp_q[tgt].size() > T) m_drop++;
            else
                for (int k = 0; k < T; k++)
                    exp_q[tgt].push_back({(k == 0), ((k == 0) ? m_evn : 4'd0), tw(eid, k)});
            m_evn = m_evn + 4'd1;
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) drive(1'b0, 1'b0, 0);
    endtask

    // Monitor: compare every lane, its copy and the drop counter each cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int n = 0; n < NN; n++) begin
                logic          ev_exp;
                logic [LW-1:0] w;
                ev_exp = (exp_q[n].size() > 0);
                w      = lane_word[n*LW +: LW];
                if (ev_exp || lane_valid[n]) begin
                    n_checks++;
                    if (lane_valid[n] !== ev_exp || (ev_exp && w !== exp_q[n][0])) begin
                        n_fail++;
                        $display("FAIL R2/R4/R6/R9 lane %0d: valid=%0b word=%h expected valid=%0b word=%h",
                                 n, lane_valid[n], w, ev_exp, ev_exp ? exp_q[n][0] : '0);
                    end
                    if (ev_exp) void'(exp_q[n].pop_front());
                end
                if (lane_valid[n+NN] !== lane_valid[n] || lane_word[(n+NN)*LW +: LW] !== w) begin
                    n_fail++;
                    $display("FAIL R8 copy lane %0d: valid=%0b word=%h expected valid=%0b word=%h",
                             n + NN, lane_valid[n+NN], lane_word[(n+NN)*LW +: LW], lane_valid[n], w);
                end
            end
            n_checks++;
            if (drop_count !== CW'(m_drop)) begin
                n_fail++;
                $display("FAIL R5/R7 drop_count=%0d expected %0d", drop_count, m_drop);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (lane_valid !== '0 || drop_count !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: lane_valid=%h drop_count=%0d expected 0 and 0", lane_valid, drop_count);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 R4 R9: back-to-back events, more than 16 so the number wraps.
        for (int e = 0; e < 20; e++) drive(1'b1, 1'b0, e);
        idle(12);

        // R2: sparse arrivals.
        for (int e = 20; e < 26; e++) begin
            drive(1'b1, 1'b0, e);
            idle(3);
        end
        idle(10);

        // R5: node 3 out of service.
        #1 node_en[3] = 1'b0;
        for (int e = 26; e < 38; e++) drive(1'b1, 1'b0, e);
        idle(12);
        #1 node_en[3] = 1'b1;

        // R3: bc0 alone, then an event that must land on node 0.
        drive(1'b0, 1'b1, 0);
        drive(1'b1, 1'b0, 38);
        @(negedge clk);
        n_checks++;
        if (lane_valid[0] !== 1'b1 || lane_word[LW-1] !== 1'b1) begin
            n_fail++;
            $display("FAIL R3 node 0 start: valid=%0b start=%0b expected 1 and 1", lane_valid[0], lane_word[LW-1]);
        end
        idle(12);

        // R6 R7: bc0 with every event piles four events on node 0.
        for (int e = 39; e < 43; e++) drive(1'b1, 1'b1, e);
        idle(25);

        // R3 with an event in the same cycle, then normal flow resumes.
        drive(1'b1, 1'b1, 43);
        for (int e = 44; e < 50; e++) drive(1'b1, 1'b0, e);
        idle(20);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule